// File: doc/BRIEF.md
# Byte/Word NOR Read Port

This block is a clocked model of the read side of a parallel NOR-type memory bus. A small internal word array, loaded with fixed contents at reset, is read through chip-enable, output-enable and write-enable pins (all active low). A mode pin selects 16-bit word access or 8-bit byte access. In byte mode the input side of data pin 15 becomes the lowest address bit and picks one half of the stored word. The upper data lanes are then left undriven.

The bus is modelled as a 16-bit data-out value plus a per-lane drive mask, in place of real tri-state pads. All pins are plain level signals sampled on the rising clock edge. There is no valid/ready flow and no back-pressure, because a bus master simply holds its pins until the data it wants appears.

A stability timer watches the effective address and the mode pin. When they have not changed for a parameterised number of clock edges, the port enters a low-power sleep state. In that state the data register is frozen and stays visible on the bus. Any change of the watched inputs leaves sleep and returns new data with the normal latency.

Top module: `nor_read_port`

## Requirements
- R1: With `word_mode`=1 and the port driving, `dq_out` equals the full 16-bit stored word and `dq_oe` is 16'hFFFF.
- R2: With `word_mode`=0 and the port driving, `dq_oe` is 16'h00FF and `dq_out[15:8]` is zero.
- R3: In byte mode, `dq_hi_in`=0 selects the low byte (bits 7:0) of the stored word and `dq_hi_in`=1 selects the high byte (bits 15:8), presented on `dq_out[7:0]`.
- R4: The port drives only when `ce_n`=0, `oe_n`=0 and `we_n`=1; for every other combination `dq_oe` and `dq_out` are both all zeros.
- R5: Outputs are registered, so they reflect the inputs sampled at the previous rising edge. While reset is held, `dq_oe`, `dq_out` and `asleep` are zero.
- R6: After reset, word address i holds high byte (8'hA0 + i) mod 256 and low byte (8'h5F - i) mod 256.
- R7: The watched key is made of `word_mode`, `addr` and, in byte mode only, `dq_hi_in`. `asleep` becomes 1 after SLEEP_CYCLES consecutive rising edges at which the key equals the key at the preceding edge. The first edge after reset counts as a change.
- R8: While asleep, the latched data stays on `dq_out` and the control pins still gate driving as in R4, without leaving sleep.
- R9: A change of `addr`, of `word_mode`, or of `dq_hi_in` in byte mode clears `asleep` at that edge. The new data appears with the same one-cycle latency as any other read.
- R10: In word mode `dq_hi_in` has no effect on the data or on the sleep timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; loads the array |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low (must be high to read) |
| word_mode | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| addr | input | ADDR_W | Word address |
| dq_hi_in | input | 1 | Input side of data pin 15; lowest address bit in byte mode |
| dq_out | output | 16 | Data value on the bus lanes (zero where not driven) |
| dq_oe | output | 16 | Per-lane drive enable |
| asleep | output | 1 | High while the port is in the sleep state |

## Verification
Every data, mask and sleep result is due exactly one rising edge after the inputs that cause it. The bench therefore changes inputs on the falling edge and samples one full period later, on the next falling edge. Sleep entry is checked edge by edge: `asleep` must still be low after SLEEP_CYCLES-1 stable edges and must be high after SLEEP_CYCLES. Wake-up is checked in the single cycle after the change, together with the new data, so any added wait would be reported.

// File: rtl/nor_rd_pkg.sv
package nor_rd_pkg;
  localparam int unsigned LANES = 16;
  localparam int unsigned BYTE_W = 8;

  typedef logic [LANES-1:0] bus_t;

  function automatic bus_t preload_word(input int unsigned idx);
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
    hi = 8'hA0 + BYTE_W'(idx);
    lo = 8'h5F - BYTE_W'(idx);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/nor_rd_array.sv
module nor_rd_array #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    rd_addr,
  output nor_rd_pkg::bus_t     rd_word
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  nor_rd_pkg::bus_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= nor_rd_pkg::preload_word(i);
    end else begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= mem[i];
    end
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/nor_rd_lanes.sv
module nor_rd_lanes (
  input  nor_rd_pkg::bus_t word_in,
  input  logic             word_mode,
  input  logic             byte_sel,
  output nor_rd_pkg::bus_t lane_data,
  output nor_rd_pkg::bus_t lane_mask
);
  localparam int unsigned BW = nor_rd_pkg::BYTE_W;

  logic [BW-1:0] picked;
  assign picked = byte_sel ? word_in[2*BW-1:BW] : word_in[BW-1:0];

  always_comb begin
    if (word_mode) begin
      lane_data = word_in;
      lane_mask = '1;
    end else begin
      lane_data = {{BW{1'b0}}, picked};
      lane_mask = {{BW{1'b0}}, {BW{1'b1}}};
    end
  end
endmodule

// File: rtl/nor_rd_sleep.sv
module nor_rd_sleep #(
  parameter int unsigned KEY_W        = 6,
  parameter int unsigned SLEEP_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] key,
  output logic             changed,
  output logic             asleep_o
);
  localparam int unsigned CNT_W = $clog2(SLEEP_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLEEP_CYCLES - 1);

  logic [KEY_W-1:0] prev_key;
  logic             prev_vld;
  logic [CNT_W-1:0] cnt;

  assign changed = !prev_vld || (key != prev_key);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_key <= '0;
      prev_vld <= 1'b0;
      cnt      <= '0;
      asleep_o <= 1'b0;
    end else begin
      prev_key <= key;
      prev_vld <= 1'b1;
      if (changed) begin
        cnt      <= '0;
        asleep_o <= 1'b0;
      end else if (cnt == LAST) begin
        asleep_o <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_vld && key != prev_key) |=> !asleep_o);

  assert_hold_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep_o && prev_vld && key == prev_key) |=> asleep_o);
endmodule

// File: rtl/nor_read_port.sv
module nor_read_port #(
  parameter int unsigned ADDR_W       = 4,
  parameter int unsigned SLEEP_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              word_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dq_hi_in,
  output logic [15:0]       dq_out,
  output logic [15:0]       dq_oe,
  output logic              asleep
);
  localparam int unsigned KEY_W = ADDR_W + 2;

  nor_rd_pkg::bus_t word_rd, lane_data, lane_mask;
  logic             byte_sel, changed, drive_now;
  logic [KEY_W-1:0] key;

  nor_rd_pkg::bus_t data_q, mask_q;
  logic             drive_q;

  assign byte_sel  = word_mode ? 1'b0 : dq_hi_in;
  assign key       = {word_mode, addr, byte_sel};
  assign drive_now = !ce_n && !oe_n && we_n;

  nor_rd_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_addr(addr), .rd_word(word_rd)
  );

  nor_rd_lanes u_lanes (
    .word_in(word_rd), .word_mode(word_mode), .byte_sel(byte_sel),
    .lane_data(lane_data), .lane_mask(lane_mask)
  );

  nor_rd_sleep #(.KEY_W(KEY_W), .SLEEP_CYCLES(SLEEP_CYCLES)) u_sleep (
    .clk(clk), .rst_n(rst_n), .key(key), .changed(changed), .asleep_o(asleep)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      mask_q  <= '0;
      drive_q <= 1'b0;
    end else begin
      drive_q <= drive_now;
      if (changed || !asleep) begin
        data_q <= lane_data;
        mask_q <= lane_mask;
      end
    end
  end

  assign dq_out = drive_q ? data_q : '0;
  assign dq_oe  = drive_q ? mask_q : '0;

  assert_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_now |=> (dq_oe == 16'h0000 && dq_out == 16'h0000));

  assert_word_lanes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_now && word_mode) |=> dq_oe == 16'hFFFF);

  assert_upper_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !word_mode |=> (dq_oe[15:8] == 8'h00 && dq_out[15:8] == 8'h00));

  assert_sleep_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && $past(asleep)) |-> $stable(data_q));
endmodule

// File: tb/nor_read_port_test.sv
`timescale 1ns/1ps
module nor_read_port_test;
  localparam int unsigned AW = 4;
  localparam int unsigned NS = 8;

  logic clk = 1'b0;
  logic rst_n, ce_n, oe_n, we_n, word_mode, dq_hi_in;
  logic [AW-1:0] addr;
  logic [15:0] dq_out, dq_oe;
  logic asleep;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  nor_read_port #(.ADDR_W(AW), .SLEEP_CYCLES(NS)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .word_mode(word_mode), .addr(addr), .dq_hi_in(dq_hi_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .asleep(asleep)
  );

  function automatic logic [15:0] exp_word(input int a);
    int hi, lo;
    hi = (160 + a) % 256;
    lo = (95 - a + 256) % 256;
    return 16'((hi << 8) | lo);
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    word_mode = 1'b1; addr = '0; dq_hi_in = 1'b0;
    run_idle(3);
    check("R5 reset oe", dq_oe, 16'h0);
    check("R5 reset data", dq_out, 16'h0);
    check("R5 reset asleep", {15'b0, asleep}, 16'h0);
    rst_n = 1'b1;
    ce_n = 1'b0; oe_n = 1'b0;

    // R1 R6 R10: word sweep, dq_hi_in toggled and ignored
    for (int a = 0; a < (1 << AW); a++) begin
      addr = AW'(a); dq_hi_in = a[0];
      step();
      check("R1/R6 word data", dq_out, exp_word(a));
      check("R1 word mask", dq_oe, 16'hFFFF);
    end

    // R2 R3: byte sweep
    word_mode = 1'b0;
    for (int a = 0; a < (1 << AW); a++) begin
      for (int b = 0; b < 2; b++) begin
        logic [15:0] w;
        addr = AW'(a); dq_hi_in = b[0];
        w = exp_word(a);
        step();
        check("R3 byte select", dq_out, {8'h00, b[0] ? w[15:8] : w[7:0]});
        check("R2 byte mask", dq_oe, 16'h00FF);
      end
    end

    // R4: control pin sweep in both modes
    addr = 4'd5; dq_hi_in = 1'b1;
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 8; c++) begin
        logic drv;
        logic [15:0] w;
        word_mode = m[0];
        {ce_n, oe_n, we_n} = c[2:0];
        drv = (c == 1);
        w = exp_word(5);
        step();
        check("R4 gate mask", dq_oe, drv ? (m[0] ? 16'hFFFF : 16'h00FF) : 16'h0);
        check("R4 gate data", dq_out, drv ? (m[0] ? w : {8'h00, w[15:8]}) : 16'h0);
      end
    end
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;

    // R7: sleep entry counted edge by edge
    word_mode = 1'b1; addr = 4'd3; dq_hi_in = 1'b0;
    step();
    check("R9 fresh key awake", {15'b0, asleep}, 16'h0);
    for (int k = 1; k <= NS; k++) begin
      step();
      check("R7 sleep timing", {15'b0, asleep}, (k >= NS) ? 16'h1 : 16'h0);
    end
    check("R8 latched data", dq_out, exp_word(3));

    // R8: control pins gate while asleep, sleep kept
    oe_n = 1'b1;
    step();
    check("R8 float asleep", dq_oe, 16'h0);
    check("R8 still asleep", {15'b0, asleep}, 16'h1);
    oe_n = 1'b0;
    step();
    check("R8 redrive asleep", dq_out, exp_word(3));

    // R10: dq_hi_in ignored in word mode while asleep
    dq_hi_in = 1'b1;
    step();
    check("R10 no wake", {15'b0, asleep}, 16'h1);
    check("R10 data same", dq_out, exp_word(3));

    // R9: address change wakes with new data at once
    addr = 4'd9;
    step();
    check("R9 addr wake", {15'b0, asleep}, 16'h0);
    check("R9 new data", dq_out, exp_word(9));

    // R9: mode change wakes
    run_idle(NS);
    check("R7 asleep again", {15'b0, asleep}, 16'h1);
    word_mode = 1'b0; dq_hi_in = 1'b0;
    step();
    check("R9 mode wake", {15'b0, asleep}, 16'h0);
    check("R9 byte data", dq_out, {8'h00, exp_word(9) & 16'h00FF});

    // R9: byte-mode lsb change wakes
    run_idle(NS);
    check("R7 byte asleep", {15'b0, asleep}, 16'h1);
    dq_hi_in = 1'b1;
    step();
    check("R9 lsb wake", {15'b0, asleep}, 16'h0);
    check("R9 lsb data", dq_out, {8'h00, exp_word(9) >> 8});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule